// File: doc/BRIEF.md
# Decode Slot Steering with Instruction Fusion

This block sits between an instruction fetch queue and a bank of decoders. Each cycle it sees a window of instructions in program order. Boundaries, byte lengths, micro-op counts and fusion-candidate pair flags are already known for every instruction. The block hands these instructions to four decode slots. Three slots accept only single-micro-op work. The fourth slot can also take one instruction that expands to two, three or four micro-ops.

Two adjacent instructions that form a candidate pair share a single slot entry. A pair is either a compare-and-branch style macro pair or a memory-read followed by an operation that consumes the loaded value. Because of this, the four slots can absorb five instructions in one cycle. The block reports how many instructions and how many bytes were taken, so that the fetch queue can advance.

An instruction that needs more than four micro-ops goes to a microcode sequencer instead. The slots issue the instructions ahead of it. The block then raises a request and stalls until the sequencer signals completion. The output group uses a valid/ready handshake.

Top module: `decode_steer`

## Requirements
- R1: Issued entries fill slot 0 upward without gaps, in program order. There are at most four entries, and slot k's index field (bits [3k+2:3k] of `slot_idx`) gives the window position of the first instruction the entry holds. Fields of slots that are not valid read zero.
- R2: A single-micro-op instruction may use any entry. At most one entry per group holds an instruction of 2 to 4 micro-ops (`win_uops` field [3i+2:3i]). When a second such instruction is reached, the group ends before it, and nothing after it is taken.
- R3: An instruction with 5 or more micro-ops ends the group, and the instructions ahead of it issue. `mc_req` rises in the cycle after that group is accepted, or in the cycle after it is seen if it is the first instruction. If the group ahead is held by `grp_ready` low, `mc_req` does not rise.
- R4: While `mc_req` is high, `grp_valid` is low and nothing is consumed. In the cycle `mc_done` is high, `take_cnt` is 1 and `take_bytes` is the length of window position 0. `mc_req` falls in the next cycle. `mc_done` has no effect while `mc_req` is low.
- R5: Bit i of `win_mf_pair` set with positions i and i+1 both valid and single-micro-op makes one entry with fuse code 1 (`slot_fuse` bits [2k+1:2k]). That entry holds 1 micro-op and consumes both instructions. If either member has more than one micro-op, no fusion takes place.
- R6: Bit i of `win_lo_pair` under the same conditions fuses the load and its dependent operation, with fuse code 2. When both flags mark the same pair, code 1 is used. Code 0 means the entry is not fused.
- R7: At most one fusion happens per cycle, and it is the first eligible pair in program order. Any later candidate pair in the same group issues as two separate entries.
- R8: A group consumes at most five instructions, which is four entries with one of them fused.
- R9: An invalid window position ends the group. A pair whose second member is invalid is not fused.
- R10: On acceptance, `take_cnt` is the number of instructions in the group and `take_bytes` is the sum of their lengths. Each length is 1 to 15, in `win_len` field [4i+3:4i].
- R11: When `grp_valid` is high and `grp_ready` is low, `take_cnt` and `take_bytes` are zero, and the slot outputs stay unchanged for an unchanged window.
- R12: During reset, `grp_valid`, `slot_vld` and `mc_req` are low. A pending microcode request is cleared.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| win_vld | input | 6 | Window position holds an instruction |
| win_len | input | 24 | Byte length per position, 4 bits each |
| win_uops | input | 18 | Micro-op count per position, 3 bits each |
| win_mf_pair | input | 5 | Bit i: positions i, i+1 are a macro fusion candidate |
| win_lo_pair | input | 5 | Bit i: positions i, i+1 are a load-op fusion candidate |
| grp_valid | output | 1 | Micro-op group present |
| grp_ready | input | 1 | Downstream accepts the group |
| slot_vld | output | 4 | Entry valid per slot |
| slot_idx | output | 12 | Window position per slot, 3 bits each |
| slot_uops | output | 12 | Micro-ops per slot, 3 bits each |
| slot_fuse | output | 8 | Fuse code per slot, 2 bits each |
| take_cnt | output | 3 | Instructions consumed this cycle |
| take_bytes | output | 7 | Bytes consumed this cycle |
| mc_req | output | 1 | Microcode sequencer request pending |
| mc_done | input | 1 | Microcode sequencer finished |

## Verification
The steering is tried with several windows:
- An all-single window shows the four-entry cap.
- Windows with one or two multi-micro-op instructions check that the complex slot is taken once and that the group stops at a second claimant.
- Windows with fusion pairs at the front, middle and tail, windows with two competing pairs, and a pair carrying both flags show the five-instruction limit, first-pair priority and the macro-over-load-op choice.
- Windows with a gap, with an invalid fusion partner, and with a multi-micro-op fusion head show that fusion depends on both members being present and single.

Directed sequences place a long instruction at the head and behind other instructions, with the downstream ready and stalled. These show when the sequencer request rises, how it holds, and that its completion consumes exactly one instruction.

// File: rtl/steer_pkg.sv
package steer_pkg;
  localparam int LEN_W = 4;
  localparam int UOP_W = 3;
  localparam int CPLX_MAX_UOPS = 4;
  localparam int FUSE_W = 2;

  typedef enum logic [FUSE_W-1:0] {
    FUSE_NONE  = 2'd0,
    FUSE_MACRO = 2'd1,
    FUSE_LDOP  = 2'd2
  } fuse_e;
endpackage

// File: rtl/steer_rst_sync.sv
module steer_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_ns
);
  logic [1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= 2'b00;
    else        sync_q <= {sync_q[0], 1'b1};
  end

  assign rst_ns = sync_q[1];
endmodule

// File: rtl/steer_fuse_pick.sv
module steer_fuse_pick
  import steer_pkg::*;
#(
  parameter int WIN = 6
) (
  input  logic [WIN-1:0]       vld,
  input  logic [WIN*UOP_W-1:0] uops,
  input  logic [WIN-2:0]       mf_pair,
  input  logic [WIN-2:0]       lo_pair,
  output logic [WIN-1:0]       fuse_at,
  output fuse_e                fuse_kind
);
  logic [WIN-1:0] single;
  logic [WIN-2:0] elig;
  logic [WIN-2:0] is_macro;

  generate
    for (genvar i = 0; i < WIN; i++) begin : g_single
      assign single[i] = vld[i] && (uops[i*UOP_W +: UOP_W] == UOP_W'(1));
    end
    for (genvar i = 0; i < WIN-1; i++) begin : g_pair
      logic pair_ok;
      assign pair_ok     = single[i] & single[i+1];
      assign is_macro[i] = pair_ok & mf_pair[i];
      assign elig[i]     = is_macro[i] | (pair_ok & lo_pair[i]);
    end
  endgenerate

  // first eligible pair in program order wins; one fusion per cycle
  always_comb begin
    logic found;
    found     = 1'b0;
    fuse_at   = '0;
    fuse_kind = FUSE_NONE;
    for (int i = 0; i < WIN-1; i++) begin
      if (elig[i] && !found) begin
        found      = 1'b1;
        fuse_at[i] = 1'b1;
        fuse_kind  = is_macro[i] ? FUSE_MACRO : FUSE_LDOP;
      end
    end
  end
endmodule

// File: rtl/steer_alloc.sv
module steer_alloc
  import steer_pkg::*;
#(
  parameter int WIN    = 6,
  parameter int SLOTS  = 4,
  parameter int IDX_W  = 3,
  parameter int CNT_W  = 3,
  parameter int BYTE_W = 7
) (
  input  logic [WIN-1:0]          vld,
  input  logic [WIN*LEN_W-1:0]    len,
  input  logic [WIN*UOP_W-1:0]    uops,
  input  logic [WIN-1:0]          fuse_at,
  input  fuse_e                   fuse_kind,
  output logic [SLOTS-1:0]        s_vld,
  output logic [SLOTS*IDX_W-1:0]  s_idx,
  output logic [SLOTS*UOP_W-1:0]  s_uops,
  output logic [SLOTS*FUSE_W-1:0] s_fuse,
  output logic [CNT_W-1:0]        n_inst,
  output logic [BYTE_W-1:0]       n_bytes,
  output logic                    mc_hit
);
  logic [LEN_W:0] pair_len [WIN];

  generate
    for (genvar i = 0; i < WIN; i++) begin : g_plen
      if (i < WIN-1) begin : g_two
        assign pair_len[i] = {1'b0, len[i*LEN_W +: LEN_W]} + {1'b0, len[(i+1)*LEN_W +: LEN_W]};
      end else begin : g_one
        assign pair_len[i] = {1'b0, len[i*LEN_W +: LEN_W]};
      end
    end
  endgenerate

  // in-order walk: stop at first instruction that cannot be placed
  always_comb begin
    int   ecnt;
    logic cplx_used;
    logic stop;
    logic skip;
    logic [UOP_W-1:0] u;
    s_vld     = '0;
    s_idx     = '0;
    s_uops    = '0;
    s_fuse    = '0;
    n_inst    = '0;
    n_bytes   = '0;
    mc_hit    = 1'b0;
    ecnt      = 0;
    cplx_used = 1'b0;
    stop      = 1'b0;
    skip      = 1'b0;
    for (int i = 0; i < WIN; i++) begin
      u = uops[i*UOP_W +: UOP_W];
      if (skip) begin
        skip = 1'b0;
      end else if (!stop) begin
        if (!vld[i]) begin
          stop = 1'b1;
        end else if (ecnt == SLOTS) begin
          stop = 1'b1;
        end else if (u > UOP_W'(CPLX_MAX_UOPS)) begin
          stop   = 1'b1;
          mc_hit = 1'b1;
        end else if (fuse_at[i]) begin
          s_vld[ecnt]                       = 1'b1;
          s_idx[ecnt*IDX_W +: IDX_W]        = IDX_W'(i);
          s_uops[ecnt*UOP_W +: UOP_W]       = UOP_W'(1);
          s_fuse[ecnt*FUSE_W +: FUSE_W]     = fuse_kind;
          n_inst  = n_inst + CNT_W'(2);
          n_bytes = n_bytes + BYTE_W'(pair_len[i]);
          ecnt    = ecnt + 1;
          skip    = 1'b1;
        end else if ((u <= UOP_W'(1)) || !cplx_used) begin
          if (u > UOP_W'(1)) cplx_used = 1'b1;
          s_vld[ecnt]                 = 1'b1;
          s_idx[ecnt*IDX_W +: IDX_W]  = IDX_W'(i);
          s_uops[ecnt*UOP_W +: UOP_W] = u;
          n_inst  = n_inst + CNT_W'(1);
          n_bytes = n_bytes + BYTE_W'(len[i*LEN_W +: LEN_W]);
          ecnt    = ecnt + 1;
        end else begin
          stop = 1'b1;
        end
      end
    end
  end
endmodule

// File: rtl/decode_steer.sv
module decode_steer
  import steer_pkg::*;
#(
  parameter int WIN   = 6,
  parameter int SLOTS = 4,
  localparam int IDX_W  = $clog2(WIN),
  localparam int CNT_W  = $clog2(SLOTS + 2),
  localparam int BYTE_W = $clog2((SLOTS + 1) * ((1 << LEN_W) - 1) + 1)
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic [WIN-1:0]          win_vld,
  input  logic [WIN*LEN_W-1:0]    win_len,
  input  logic [WIN*UOP_W-1:0]    win_uops,
  input  logic [WIN-2:0]          win_mf_pair,
  input  logic [WIN-2:0]          win_lo_pair,
  output logic                    grp_valid,
  input  logic                    grp_ready,
  output logic [SLOTS-1:0]        slot_vld,
  output logic [SLOTS*IDX_W-1:0]  slot_idx,
  output logic [SLOTS*UOP_W-1:0]  slot_uops,
  output logic [SLOTS*FUSE_W-1:0] slot_fuse,
  output logic [CNT_W-1:0]        take_cnt,
  output logic [BYTE_W-1:0]       take_bytes,
  output logic                    mc_req,
  input  logic                    mc_done
);
  logic rst_ns;

  steer_rst_sync u_rst (
    .clk    (clk),
    .rst_n  (rst_n),
    .rst_ns (rst_ns)
  );

  logic [WIN-1:0] fuse_at;
  fuse_e          fuse_kind;

  steer_fuse_pick #(.WIN(WIN)) u_pick (
    .vld       (win_vld),
    .uops      (win_uops),
    .mf_pair   (win_mf_pair),
    .lo_pair   (win_lo_pair),
    .fuse_at   (fuse_at),
    .fuse_kind (fuse_kind)
  );

  logic [SLOTS-1:0]        a_vld;
  logic [SLOTS*IDX_W-1:0]  a_idx;
  logic [SLOTS*UOP_W-1:0]  a_uops;
  logic [SLOTS*FUSE_W-1:0] a_fuse;
  logic [CNT_W-1:0]        a_inst;
  logic [BYTE_W-1:0]       a_bytes;
  logic                    a_mc;

  steer_alloc #(
    .WIN(WIN), .SLOTS(SLOTS), .IDX_W(IDX_W), .CNT_W(CNT_W), .BYTE_W(BYTE_W)
  ) u_alloc (
    .vld       (win_vld),
    .len       (win_len),
    .uops      (win_uops),
    .fuse_at   (fuse_at),
    .fuse_kind (fuse_kind),
    .s_vld     (a_vld),
    .s_idx     (a_idx),
    .s_uops    (a_uops),
    .s_fuse    (a_fuse),
    .n_inst    (a_inst),
    .n_bytes   (a_bytes),
    .mc_hit    (a_mc)
  );

  // microcode pending state: next-state and register kept apart
  logic pend_q, pend_d, pend_en;
  logic issue_en, fire, mc_start, done_take;

  assign issue_en  = rst_ns & ~pend_q;
  assign fire      = grp_valid & grp_ready;
  assign mc_start  = issue_en & a_mc & (fire | ~(|a_vld));
  assign done_take = pend_q & mc_done;

  always_comb begin
    pend_en = pend_q ? mc_done : mc_start;
    pend_d  = ~pend_q;
  end

  always_ff @(posedge clk or negedge rst_ns) begin
    if (!rst_ns)      pend_q <= 1'b0;
    else if (pend_en) pend_q <= pend_d;
  end

  always_comb begin
    slot_vld  = issue_en ? a_vld  : '0;
    slot_idx  = issue_en ? a_idx  : '0;
    slot_uops = issue_en ? a_uops : '0;
    slot_fuse = issue_en ? a_fuse : '0;
    grp_valid = |slot_vld;
    mc_req    = pend_q;
    if (fire) begin
      take_cnt   = a_inst;
      take_bytes = a_bytes;
    end else if (done_take) begin
      take_cnt   = CNT_W'(1);
      take_bytes = BYTE_W'(win_len[LEN_W-1:0]);
    end else begin
      take_cnt   = '0;
      take_bytes = '0;
    end
  end

  // ---------------- assertions ----------------
  logic [SLOTS-1:0] multi_s, fused_s;

  generate
    for (genvar k = 0; k < SLOTS; k++) begin : g_chk
      assign multi_s[k] = slot_uops[k*UOP_W +: UOP_W] > UOP_W'(1);
      assign fused_s[k] = slot_fuse[k*FUSE_W +: FUSE_W] != FUSE_NONE;

      p_fuse_one_uop_r5: assert property (@(posedge clk) disable iff (!rst_ns)
        fused_s[k] |-> (slot_uops[k*UOP_W +: UOP_W] == UOP_W'(1)));

      if (k < SLOTS-1) begin : g_pack
        p_slots_packed_r1: assert property (@(posedge clk) disable iff (!rst_ns)
          slot_vld[k+1] |-> slot_vld[k]);
      end
    end
  endgenerate

  p_one_multi_r2: assert property (@(posedge clk) disable iff (!rst_ns)
    $countones(multi_s) <= 1);

  p_one_fusion_r7: assert property (@(posedge clk) disable iff (!rst_ns)
    $countones(fused_s) <= 1);

  p_mc_hold_r4: assert property (@(posedge clk) disable iff (!rst_ns)
    (mc_req && !mc_done) |=> mc_req);

  p_mc_quiet_r4: assert property (@(posedge clk) disable iff (!rst_ns)
    mc_req |-> (!grp_valid && take_cnt <= CNT_W'(1)));

  p_take_limit_r8: assert property (@(posedge clk) disable iff (!rst_ns)
    take_cnt <= CNT_W'(SLOTS + 1));

  p_stall_r11: assert property (@(posedge clk) disable iff (!rst_ns)
    (grp_valid && !grp_ready) |-> (take_cnt == '0 && take_bytes == '0));

  p_reset_r12: assert property (@(posedge clk)
    !rst_ns |-> (!grp_valid && slot_vld == '0 && !mc_req));
endmodule

// File: tb/decode_steer_tb.sv
module decode_steer_tb;
  logic        clk = 1'b0;
  logic        rst_n;
  logic [5:0]  win_vld;
  logic [23:0] win_len;
  logic [17:0] win_uops;
  logic [4:0]  win_mf_pair, win_lo_pair;
  logic        grp_valid, grp_ready;
  logic [3:0]  slot_vld;
  logic [11:0] slot_idx, slot_uops;
  logic [7:0]  slot_fuse;
  logic [2:0]  take_cnt;
  logic [6:0]  take_bytes;
  logic        mc_req, mc_done;

  int checks = 0;
  int failures = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  decode_steer u_dut (
    .clk(clk), .rst_n(rst_n), .win_vld(win_vld), .win_len(win_len),
    .win_uops(win_uops), .win_mf_pair(win_mf_pair), .win_lo_pair(win_lo_pair),
    .grp_valid(grp_valid), .grp_ready(grp_ready), .slot_vld(slot_vld),
    .slot_idx(slot_idx), .slot_uops(slot_uops), .slot_fuse(slot_fuse),
    .take_cnt(take_cnt), .take_bytes(take_bytes), .mc_req(mc_req), .mc_done(mc_done)
  );

  // lengths by position 0..5: 3,5,1,15,2,7 ; prefix sums 3,8,9,24,26,33
  localparam logic [23:0] LENS = 24'h72F153;
  localparam int NV = 11;
  //                                     V0       V1       V2       V3       V4       V5       V6       V7       V8       V9       V10
  localparam logic [5:0]  T_VLD [NV] = '{6'h3f,   6'h3f,   6'h3f,   6'h3f,   6'h3f,   6'h3f,   6'h3f,   6'h3b,   6'h03,   6'h3f,   6'h3f};
  localparam logic [17:0] T_UOP [NV] = '{18'o111111,18'o111131,18'o111421,18'o111111,18'o111111,18'o111111,18'o111111,18'o111111,18'o111111,18'o111112,18'o111111};
  localparam logic [4:0]  T_MF  [NV] = '{5'h00,   5'h00,   5'h00,   5'h01,   5'h00,   5'h01,   5'h02,   5'h00,   5'h02,   5'h01,   5'h08};
  localparam logic [4:0]  T_LO  [NV] = '{5'h00,   5'h00,   5'h00,   5'h00,   5'h04,   5'h04,   5'h02,   5'h00,   5'h00,   5'h00,   5'h00};
  localparam logic [2:0]  E_CNT [NV] = '{3'd4,    3'd4,    3'd2,    3'd5,    3'd5,    3'd5,    3'd5,    3'd2,    3'd2,    3'd4,    3'd5};
  localparam logic [6:0]  E_BYT [NV] = '{7'd24,   7'd24,   7'd8,    7'd26,   7'd26,   7'd26,   7'd26,   7'd8,    7'd8,    7'd24,   7'd26};
  localparam logic [3:0]  E_SV  [NV] = '{4'hf,    4'hf,    4'h3,    4'hf,    4'hf,    4'hf,    4'hf,    4'h3,    4'h3,    4'hf,    4'hf};
  localparam logic [11:0] E_IDX [NV] = '{12'o3210,12'o3210,12'o0010,12'o4320,12'o4210,12'o4320,12'o4310,12'o0010,12'o0010,12'o3210,12'o3210};
  localparam logic [11:0] E_UOP [NV] = '{12'o1111,12'o1131,12'o0021,12'o1111,12'o1111,12'o1111,12'o1111,12'o0011,12'o0011,12'o1112,12'o1111};
  localparam logic [7:0]  E_FUS [NV] = '{8'h00,   8'h00,   8'h00,   8'h01,   8'h20,   8'h01,   8'h04,   8'h00,   8'h00,   8'h00,   8'h40};
  // V0 R1 cap, V1 R2 complex, V2 R2 second multi, V3 R5 macro, V4 R6 load-op, V5 R7 first pair,
  // V6 R6 macro wins, V7 R9 gap, V8 R9 partner absent, V9 R5 multi head, V10 R8 tail pair
  localparam string T_REQ [NV] = '{"R1","R2","R2","R5","R6","R7","R6","R9","R9","R5","R8"};

  task automatic check(string req, int act, int exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic drive(logic [5:0] v, logic [17:0] u, logic [4:0] mf, logic [4:0] lo);
    win_vld = v; win_uops = u; win_mf_pair = mf; win_lo_pair = lo;
  endtask

  task automatic summary();
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      failures++;
      $display("FAIL watchdog actual=hung expected=finish");
      summary();
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; grp_ready = 1'b1; mc_done = 1'b0; win_len = LENS;
    drive(6'h3f, 18'o111111, 5'h00, 5'h00);
    repeat (3) @(negedge clk);
    #1;
    // R12: held in reset
    check("R12 grp_valid", grp_valid, 0);
    check("R12 slot_vld", slot_vld, 0);
    check("R12 mc_req", mc_req, 0);
    @(negedge clk); rst_n = 1'b1;
    repeat (3) @(negedge clk);
    #1;
    check("R12 valid after release", grp_valid, 1);

    // table walk
    for (int n = 0; n < NV; n++) begin
      @(negedge clk);
      drive(T_VLD[n], T_UOP[n], T_MF[n], T_LO[n]);
      #1;
      check({T_REQ[n], " R10 take_cnt"}, take_cnt, E_CNT[n]);
      check({T_REQ[n], " R10 take_bytes"}, take_bytes, E_BYT[n]);
      check({T_REQ[n], " slot_vld"}, slot_vld, E_SV[n]);
      check({T_REQ[n], " slot_idx"}, slot_idx, E_IDX[n]);
      check({T_REQ[n], " slot_uops"}, slot_uops, E_UOP[n]);
      check({T_REQ[n], " slot_fuse"}, slot_fuse, E_FUS[n]);
    end

    // R11: stalled downstream
    @(negedge clk);
    drive(6'h3f, 18'o111111, 5'h00, 5'h00); grp_ready = 1'b0;
    #1;
    check("R11 valid", grp_valid, 1);
    check("R11 take_cnt", take_cnt, 0);
    check("R11 take_bytes", take_bytes, 0);
    // R4: mc_done without pending request has no effect
    mc_done = 1'b1;
    #1;
    check("R4 stray done take", take_cnt, 0);
    @(negedge clk); mc_done = 1'b0;
    #1;
    check("R11 slots held", slot_idx, 12'o3210);
    check("R4 stray done no req", mc_req, 0);

    // R3: long instruction behind a held group does not request
    drive(6'h3f, 18'o111161, 5'h00, 5'h00);
    #1;
    check("R3 group ahead", slot_vld, 4'h1);
    @(negedge clk);
    #1;
    check("R3 no req while held", mc_req, 0);
    grp_ready = 1'b1;
    #1;
    check("R3 take ahead", take_cnt, 1);
    check("R3 bytes ahead", take_bytes, 3);
    @(negedge clk);
    drive(6'h3f, 18'o111116, 5'h00, 5'h00);
    #1;
    check("R3 req after accept", mc_req, 1);
    mc_done = 1'b1;
    #1;
    check("R4 done take", take_cnt, 1);
    @(negedge clk); mc_done = 1'b0;
    drive(6'h3f, 18'o111111, 5'h00, 5'h00);

    // R3/R4: long instruction at position 2
    @(negedge clk);
    drive(6'h3f, 18'o111511, 5'h00, 5'h00);
    #1;
    check("R3 take before long", take_cnt, 2);
    check("R3 bytes before long", take_bytes, 8);
    check("R3 no req yet", mc_req, 0);
    @(negedge clk);
    drive(6'h3f, 18'o111115, 5'h00, 5'h00);
    #1;
    check("R3 req raised", mc_req, 1);
    check("R4 no group", grp_valid, 0);
    check("R4 nothing taken", take_cnt, 0);
    @(negedge clk);
    #1;
    check("R4 req held", mc_req, 1);
    mc_done = 1'b1;
    #1;
    check("R4 take one", take_cnt, 1);
    check("R4 take len", take_bytes, 3);
    @(negedge clk);
    mc_done = 1'b0;
    drive(6'h3f, 18'o111111, 5'h00, 5'h00);
    #1;
    check("R4 req cleared", mc_req, 0);
    check("R4 resumes", grp_valid, 1);

    // R3: long instruction at head with downstream stalled
    @(negedge clk);
    drive(6'h3f, 18'o111116, 5'h00, 5'h00); grp_ready = 1'b0;
    #1;
    check("R3 head no group", grp_valid, 0);
    @(negedge clk);
    #1;
    check("R3 head req", mc_req, 1);
    mc_done = 1'b1;
    @(negedge clk);
    mc_done = 1'b0;
    #1;
    check("R4 head cleared", mc_req, 0);

    done = 1'b1;
    summary();
    $finish;
  end
endmodule